// File: doc/BRIEF.md
# Frame-Interleaved Bank Group Scheduler

This controller hands out feature-map SRAM bank groups to a chain of streaming compute units. Each unit owns a four-group window. A unit's window starts two groups above the window of the unit before it, so neighbouring units share two groups. These shared groups carry the results from one unit to the next. A frame uses only the half of the window whose group parity matches the parity of the frame index. Two consecutive frames can therefore run in neighbouring units at the same time without touching the same storage.

Software or a sequencer starts a frame in a unit with a one-cycle start pulse. The pulse carries the frame parity and the number of layers the unit will run for that frame. While the frame runs, the unit's first group in the window for that parity is its "ping" group, and the group two above it is its "pong" group. The first layer reads ping and writes pong. Every layer-done pulse swaps the two roles. The unit's own layer-done pulse after its last layer frees it for the next frame. The scheduler also guards the shared groups. If two busy units would write the same group in one cycle, the lower-numbered unit keeps its write enable, the other loses it, and an error flag is raised.

Top module: `bank_grp_sched`

## Requirements
- R1: After reset every unit reports ready, every read and write enable is low, and the conflict flag is low.
- R2: A start pulse to a ready unit with a non-zero layer count makes the unit busy from the next clock edge: its read enable goes high, its write enable goes high unless a clash suppresses it (R9), and its ready goes low. The layer count and frame parity are sampled at that edge.
- R3: Unit u (0-based) only ever selects groups 2u to 2u+3. Both its read group and its write group have bit 0 equal to the sampled frame parity.
- R4: In layer 0, unit u reads group 2u+p and writes group 2u+2+p, where p is the frame parity. Each layer-done pulse while busy swaps the read group and the write group.
- R5: After the unit's layer-done pulse for its last layer, the unit is ready again, and its read and write enables are low.
- R6: A start pulse to a busy unit is ignored. The group selects, the layer position and the sampled layer count are all unchanged.
- R7: A start pulse with a layer count of zero is ignored, and the unit stays ready.
- R8: When the layer count is odd, the last layer of unit u writes group 2(u+1)+p. This is the group that unit u+1 reads in its first layer.
- R9: If two busy units select the same write group in a cycle, only the lower-numbered one has its write enable high. The conflict flag is high in the following cycle, and low in any cycle after a cycle with no such clash.
- R10: A layer-done pulse to a ready unit is ignored. The next frame still starts at layer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | NUNIT | One-cycle start pulse per unit |
| frm_odd | input | 1 | Bit 0 of the frame index, sampled at start |
| layer_cnt | input | NUNIT*LCW | Layer count per unit, unit u in bits [u*LCW +: LCW] |
| layer_done | input | NUNIT | One-cycle end-of-layer pulse per unit |
| rd_grp | output | NUNIT*GW | Read bank group per unit, unit u in bits [u*GW +: GW] |
| wr_grp | output | NUNIT*GW | Write bank group per unit, same packing |
| rd_en | output | NUNIT | Read enable per unit (unit busy) |
| wr_en | output | NUNIT | Write enable per unit after clash arbitration |
| unit_rdy | output | NUNIT | Unit can accept a new frame |
| conflict_err | output | 1 | A write clash occurred in the previous cycle |

## Verification
The selects, enables and ready outputs come straight from registered state. They change one edge after a start or layer-done pulse, so the bench drives a pulse on a falling edge, removes it on the next falling edge, and compares the outputs at that point. Write-enable arbitration is combinational on that same state, so a suppressed enable shows up in the same sample as the clash. The conflict flag is registered once more. It is therefore checked one full cycle later, and again one cycle after the clash has gone.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  // Offset between the windows of neighbouring compute units.
  localparam int unsigned BGS_STEP = 2;
  // Distance between the ping and pong group of one frame parity.
  localparam int unsigned BGS_SPAN = 2;
  // Groups needed by a chain of n units.
  function automatic int unsigned bgs_groups_needed(input int unsigned n);
    return n * BGS_STEP + BGS_SPAN;
  endfunction
endpackage

// File: rtl/bgs_grp_map.sv
module bgs_grp_map #(
  parameter int unsigned GW   = 3,
  parameter int unsigned UNIT = 0
) (
  input  logic          par_i,
  input  logic          far_i,
  output logic [GW-1:0] grp_o
);
  import bgs_pkg::*;
  localparam logic [GW-1:0] BASE = GW'(UNIT * BGS_STEP);
  localparam logic [GW-1:0] SPAN = GW'(BGS_SPAN);

  always_comb begin
    grp_o = BASE + (far_i ? SPAN : '0) + {{(GW-1){1'b0}}, par_i};
  end
endmodule

// File: rtl/bgs_unit_seq.sv
module bgs_unit_seq #(
  parameter int unsigned LCW  = 4,
  parameter int unsigned GW   = 3,
  parameter int unsigned UNIT = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           done_i,
  input  logic           par_i,
  input  logic [LCW-1:0] cnt_i,
  output logic           busy_o,
  output logic [GW-1:0]  rd_grp_o,
  output logic [GW-1:0]  wr_grp_o
);
  logic           busy_q, busy_d;
  logic           par_q, par_d;
  logic [LCW-1:0] lyr_q, lyr_d;
  logic [LCW-1:0] last_q, last_d;
  logic           accept, advance, upd_en;
  logic           phase;

  assign accept  = !busy_q && start_i && (cnt_i != '0);
  assign advance = busy_q && done_i;
  assign upd_en  = accept || advance;

  always_comb begin
    busy_d = busy_q;
    par_d  = par_q;
    lyr_d  = lyr_q;
    last_d = last_q;
    if (accept) begin
      busy_d = 1'b1;
      par_d  = par_i;
      lyr_d  = '0;
      last_d = cnt_i - 1'b1;
    end else if (advance) begin
      if (lyr_q == last_q) begin
        busy_d = 1'b0;
      end else begin
        lyr_d = lyr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      par_q  <= 1'b0;
      lyr_q  <= '0;
      last_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      par_q  <= par_d;
      lyr_q  <= lyr_d;
      last_q <= last_d;
    end
  end

  assign phase  = lyr_q[0];
  assign busy_o = busy_q;

  bgs_grp_map #(.GW(GW), .UNIT(UNIT)) rd_map_i (
    .par_i (par_q),
    .far_i (phase),
    .grp_o (rd_grp_o)
  );

  bgs_grp_map #(.GW(GW), .UNIT(UNIT)) wr_map_i (
    .par_i (par_q),
    .far_i (!phase),
    .grp_o (wr_grp_o)
  );
endmodule

// File: rtl/bgs_wr_arb.sv
module bgs_wr_arb #(
  parameter int unsigned NUNIT = 3,
  parameter int unsigned GW    = 3
) (
  input  logic [NUNIT-1:0]    req_i,
  input  logic [NUNIT*GW-1:0] grp_i,
  output logic [NUNIT-1:0]    gnt_o,
  output logic                clash_o
);
  logic [NUNIT-1:0] blocked;

  always_comb begin
    blocked = '0;
    for (int u = 1; u < NUNIT; u++) begin
      for (int v = 0; v < u; v++) begin
        if (req_i[u] && req_i[v] && (grp_i[u*GW +: GW] == grp_i[v*GW +: GW])) begin
          blocked[u] = 1'b1;
        end
      end
    end
    gnt_o   = req_i & ~blocked;
    clash_o = |blocked;
  end
endmodule

// File: rtl/bank_grp_sched.sv
module bank_grp_sched #(
  parameter int unsigned NUNIT = 3,
  parameter int unsigned NGRP  = 8,
  parameter int unsigned LCW   = 4,
  parameter int unsigned GW    = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUNIT-1:0]     frm_start,
  input  logic                 frm_odd,
  input  logic [NUNIT*LCW-1:0] layer_cnt,
  input  logic [NUNIT-1:0]     layer_done,
  output logic [NUNIT*GW-1:0]  rd_grp,
  output logic [NUNIT*GW-1:0]  wr_grp,
  output logic [NUNIT-1:0]     rd_en,
  output logic [NUNIT-1:0]     wr_en,
  output logic [NUNIT-1:0]     unit_rdy,
  output logic                 conflict_err
);
  import bgs_pkg::*;

  initial begin
    if (bgs_groups_needed(NUNIT) > NGRP) begin
      $display("bank_grp_sched: NGRP too small for NUNIT");
    end
  end

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUNIT-1:0] busy;

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    bgs_unit_seq #(.LCW(LCW), .GW(GW), .UNIT(u)) seq_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .start_i  (frm_start[u]),
      .done_i   (layer_done[u]),
      .par_i    (frm_odd),
      .cnt_i    (layer_cnt[u*LCW +: LCW]),
      .busy_o   (busy[u]),
      .rd_grp_o (rd_grp[u*GW +: GW]),
      .wr_grp_o (wr_grp[u*GW +: GW])
    );
  end

  logic clash;

  bgs_wr_arb #(.NUNIT(NUNIT), .GW(GW)) arb_i (
    .req_i   (busy),
    .grp_i   (wr_grp),
    .gnt_o   (wr_en),
    .clash_o (clash)
  );

  assign rd_en    = busy;
  assign unit_rdy = ~busy;

  logic err_d, err_q;
  assign err_d = clash;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end
  assign conflict_err = err_q;
endmodule

// File: rtl/bank_grp_sched_chk.sv
module bank_grp_sched_chk #(
  parameter int unsigned NUNIT = 3,
  parameter int unsigned GW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUNIT-1:0]    frm_start,
  input logic [NUNIT-1:0]    layer_done,
  input logic [NUNIT*GW-1:0] rd_grp,
  input logic [NUNIT*GW-1:0] wr_grp,
  input logic [NUNIT-1:0]    rd_en,
  input logic [NUNIT-1:0]    wr_en,
  input logic                conflict_err
);
  for (genvar u = 0; u < NUNIT; u++) begin : g_u
    localparam logic [GW-1:0] LO = GW'(2 * u);
    localparam logic [GW-1:0] HI = GW'(2 * u + 3);

    // R3: selects stay inside the unit's window
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[u] |-> (rd_grp[u*GW +: GW] >= LO) && (rd_grp[u*GW +: GW] <= HI) &&
                   (wr_grp[u*GW +: GW] >= LO) && (wr_grp[u*GW +: GW] <= HI));

    // R3/R4: read and write groups differ but share the frame parity
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[u] |-> (rd_grp[u*GW +: GW] != wr_grp[u*GW +: GW]) &&
                   (rd_grp[u*GW] == wr_grp[u*GW]));

    // R4: a layer end swaps the roles if the unit stays busy
    p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[u] && layer_done[u]) |=>
        (!rd_en[u] || (rd_grp[u*GW +: GW] == $past(wr_grp[u*GW +: GW]))));

    // R6: a start pulse to a busy unit changes nothing
    p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[u] && frm_start[u] && !layer_done[u]) |=>
        (rd_en[u] && $stable(rd_grp[u*GW +: GW]) && $stable(wr_grp[u*GW +: GW])));

    // R5: an idle unit never writes
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[u] |-> !wr_en[u]);

    for (genvar v = u + 1; v < NUNIT; v++) begin : g_v
      // R9: no two enabled writers on one group
      p_no_dup_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en[u] && wr_en[v] && (wr_grp[u*GW +: GW] == wr_grp[v*GW +: GW])));

      // R9: a clash between busy units is flagged one cycle later
      p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[u] && rd_en[v] && (wr_grp[u*GW +: GW] == wr_grp[v*GW +: GW])) |=>
          conflict_err);
    end
  end
endmodule

bind bank_grp_sched bank_grp_sched_chk #(.NUNIT(NUNIT), .GW(GW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .frm_start    (frm_start),
  .layer_done   (layer_done),
  .rd_grp       (rd_grp),
  .wr_grp       (wr_grp),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .conflict_err (conflict_err)
);

// File: tb/bank_grp_sched_tb_top.sv
module bank_grp_sched_tb_top;
  localparam int NU  = 3;
  localparam int NG  = 8;
  localparam int LCW = 4;
  localparam int GW  = 3;

  logic              clk;
  logic              rst_n;
  logic [NU-1:0]     frm_start;
  logic              frm_odd;
  logic [NU*LCW-1:0] layer_cnt;
  logic [NU-1:0]     layer_done;
  logic [NU*GW-1:0]  rd_grp;
  logic [NU*GW-1:0]  wr_grp;
  logic [NU-1:0]     rd_en;
  logic [NU-1:0]     wr_en;
  logic [NU-1:0]     unit_rdy;
  logic              conflict_err;

  int vectors;
  int fails;
  bit ended;

  bank_grp_sched #(.NUNIT(NU), .NGRP(NG), .LCW(LCW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_start    (frm_start),
    .frm_odd      (frm_odd),
    .layer_cnt    (layer_cnt),
    .layer_done   (layer_done),
    .rd_grp       (rd_grp),
    .wr_grp       (wr_grp),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .unit_rdy     (unit_rdy),
    .conflict_err (conflict_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_grp(input int u, input int p, input int far);
    return 2 * u + 2 * far + p;
  endfunction

  function automatic int rdg(input int u);
    return int'(rd_grp[u*GW +: GW]);
  endfunction

  function automatic int wrg(input int u);
    return int'(wr_grp[u*GW +: GW]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic do_start(input int u, input int p, input int n);
    @(negedge clk);
    frm_odd = p[0];
    layer_cnt[u*LCW +: LCW] = LCW'(n);
    frm_start[u] = 1'b1;
    @(negedge clk);
    frm_start = '0;
  endtask

  task automatic do_done(input int u);
    @(negedge clk);
    layer_done[u] = 1'b1;
    @(negedge clk);
    layer_done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    wrap_up();
  end

  initial begin
    vectors = 0;
    fails = 0;
    ended = 1'b0;
    frm_start = '0;
    frm_odd = 1'b0;
    layer_cnt = '0;
    layer_done = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ready", int'(unit_rdy), 7);
    chk("R1 rd_en", int'(rd_en), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 err", int'(conflict_err), 0);

    // Sweep: every unit, both parities, layer counts 1..5
    for (int u = 0; u < NU; u++) begin
      for (int p = 0; p < 2; p++) begin
        for (int n = 1; n <= 5; n++) begin
          do_start(u, p, n);
          chk("R2 ready low", int'(unit_rdy[u]), 0);
          for (int j = 0; j < n; j++) begin
            chk("R2 rd_en", int'(rd_en[u]), 1);
            chk("R2 wr_en", int'(wr_en[u]), 1);
            chk("R4 rd group", rdg(u), exp_grp(u, p, j % 2));
            chk("R4 wr group", wrg(u), exp_grp(u, p, 1 - (j % 2)));
            chk("R3 parity", rdg(u) % 2, p);
            if (j == n - 1 && (n % 2) == 1 && u < NU - 1) begin
              chk("R8 hand-off", wrg(u), exp_grp(u + 1, p, 0));
            end
            do_done(u);
          end
          chk("R5 ready", int'(unit_rdy[u]), 1);
          chk("R5 rd_en", int'(rd_en[u]), 0);
          chk("R5 wr_en", int'(wr_en[u]), 0);
          chk("R5 others idle", int'(rd_en), 0);
        end
      end
    end

    // R6: start while busy is ignored
    do_start(0, 0, 3);
    do_done(0);
    chk("R6 pre rd", rdg(0), 2);
    do_start(0, 1, 5);
    chk("R6 still busy", int'(rd_en[0]), 1);
    chk("R6 rd kept", rdg(0), 2);
    chk("R6 wr kept", wrg(0), 0);
    do_done(0);
    chk("R6 layer2 rd", rdg(0), 0);
    do_done(0);
    chk("R6 count kept", int'(unit_rdy[0]), 1);

    // R7: zero layer count ignored
    do_start(1, 0, 0);
    chk("R7 ready", int'(unit_rdy[1]), 1);
    chk("R7 rd_en", int'(rd_en[1]), 0);

    // R10: layer end to an idle unit ignored
    do_done(2);
    chk("R10 idle", int'(unit_rdy[2]), 1);
    do_start(2, 0, 2);
    chk("R10 layer0 rd", rdg(2), 4);
    chk("R10 layer0 wr", wrg(2), 6);
    do_done(2);
    chk("R10 layer1 rd", rdg(2), 6);
    do_done(2);
    chk("R10 done", int'(unit_rdy[2]), 1);

    // R9: unit 1 in layer 1 writes group 2, unit 0 in layer 0 writes group 2
    do_start(1, 0, 3);
    do_done(1);
    chk("R9 u1 wr", wrg(1), 2);
    chk("R9 no err yet", int'(conflict_err), 0);
    do_start(0, 0, 3);
    chk("R9 u0 wr", wrg(0), 2);
    chk("R9 enables", int'(wr_en), 1);
    @(negedge clk);
    chk("R9 err set", int'(conflict_err), 1);
    do_done(0);
    chk("R9 err held", int'(conflict_err), 1);
    chk("R9 enables freed", int'(wr_en), 3);
    @(negedge clk);
    chk("R9 err clear", int'(conflict_err), 0);
    do_done(0);
    do_done(0);
    do_done(1);
    do_done(1);
    chk("R5 all ready", int'(unit_rdy), 7);

    wrap_up();
  end
endmodule